// File: doc/BRIEF.md
# Three-Wire Link Flush Sequencer

This block brings a three-wire handshake link (a clock line driven by the peer, an acknowledge line driven by this side, and a shared bidirectional data line) back to a known idle state after a transfer error. The link moves through four phases per handshake. The peer pulls its clock low to go from P0 to P1. This side lowers acknowledge to go from P1 to P2. The peer raises its clock to go from P2 to P3. This side raises acknowledge to return from P3 to P0.

A start pulse launches one of two sequences. Flusher mode pulls the data line low for a fixed number of complete handshakes. It then drives data high in the next P1 and hands over to flushee mode. Flushee mode can also be started directly. It is used when a transmit termination has seen the peer flushing. In flushee mode the block lets go of the data line and reads it in every P3. It keeps handshaking while the peer holds data low. It finishes with acknowledge high, in P0.

Both incoming link lines pass through a synchronizer. Every wait for a clock edge is bounded by a cycle limit, and a timeout ends the sequence with a flag.

Top module: `link_flush_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, acknowledge is high, the data output enable is low, and done and timeout are low.
- R2: In flusher mode, every handshake of the flush count takes place with the data output enable high and the data line low.
- R3: Flusher mode completes exactly FLUSH_CYCLES handshakes with data low. At the next peer clock fall, it drives the data line high while keeping acknowledge high.
- R4: Acknowledge falls only after the synchronized peer clock has been seen low. It rises only after that clock has been seen high, or at a timeout.
- R5: Flushee mode started while the peer clock is low keeps acknowledge high and finishes nothing until the peer clock rises.
- R6: In flushee mode the data output enable is low. Each P3 sample that reads data low costs exactly one more handshake, which is one more acknowledge fall.
- R7: A P3 sample that reads data high ends the sequence. Done is a one-cycle pulse, acknowledge is high, the data enable is low, and timeout is low.
- R8: If a wait for a peer clock edge lasts WAIT_LIMIT cycles, done pulses with timeout high, acknowledge is driven high and the data line is released. Timeout is never high without done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a sequence when idle |
| flushee_mode_i | input | 1 | Sequence select at start: 0 flusher, 1 flushee only |
| link_clk_i | input | 1 | Peer-driven link clock line (asynchronous) |
| link_data_i | input | 1 | Resolved level of the shared data line (asynchronous) |
| ack_o | output | 1 | Acknowledge line to the peer |
| data_o | output | 1 | Level driven onto the data line when enabled |
| data_oe_o | output | 1 | Data line drive enable |
| done_o | output | 1 | One-cycle pulse when a sequence ends |
| timeout_o | output | 1 | High with done when the sequence ended on a timeout |

## Verification
The in-line assertions watch, on every cycle, the edge ordering of acknowledge against the synchronized peer clock. They also watch that data is held low throughout the flusher handshakes, that the line is released throughout flushee mode, that the handshake count stays in range, and that done and timeout pulse correctly. The exact number of flusher handshakes, the release of data in the right phase, the count of extra flushee rounds against how long the peer keeps data low, the direct-entry case with the clock already low, and the timeout latency only show up in the bench. There a peer model plays each scenario against the ports.

// File: rtl/lfs_pkg.sv
// Shared types for the link flush sequencer.
// Assumes: one sequencer state register per instance.
package lfs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,      // P0, nothing in progress
        ST_FL_LO,     // flusher: waiting for peer clock low (P0->P1)
        ST_FL_HI,     // flusher: waiting for peer clock high (P2->P3)
        ST_FL_REL,    // flusher: count reached, waiting for P1 to raise data
        ST_FE_ENTRY,  // flushee: release data, decide on clock level
        ST_FE_HI,     // flushee: waiting for peer clock high (reach P3)
        ST_FE_SAMPLE, // flushee: let data settle, sample it in P3
        ST_FE_LO,     // flushee: waiting for peer clock low (P0->P1)
        ST_DONE       // one-cycle completion
    } lfs_state_e;

    // True in states that wait on a peer clock edge and may time out.
    function automatic logic lfs_is_edge_wait(lfs_state_e s);
        return (s == ST_FL_LO) || (s == ST_FL_HI) || (s == ST_FL_REL) ||
               (s == ST_FE_HI) || (s == ST_FE_LO);
    endfunction

endpackage

// File: rtl/lfs_sync.sv
// Multi-bit, multi-stage synchronizer for asynchronous link lines.
// Assumes: each bit is independent (no bus coherency needed), STAGES >= 2.
module lfs_sync #(
    parameter int          WIDTH   = 2,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] sh_q;

        // Shift the raw line through the flop chain, reset to idle level.
        always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= {STAGES{RST_VAL[b]}};
            else        sh_q <= {sh_q[STAGES-2:0], din[b]};
        end

        assign dout[b] = sh_q[STAGES-1];
    end

endmodule

// File: rtl/lfs_timer.sv
// Wait timer: counts cycles spent in one sequencer state, restarts on each
// state change, saturates at WAIT_LIMIT-1.
// Assumes: the controller only honours expiry in edge-wait states.
module lfs_timer #(
    parameter int WAIT_LIMIT = 4096,
    localparam int CW = $clog2(WAIT_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          clear_i,
    output logic [CW-1:0] cnt_o,
    output logic          expired_o
);

    localparam logic [CW-1:0] LAST = CW'(WAIT_LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Count cycles in the current state; clear on state change or idle.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i || !run_i) cnt_q <= '0;
        else if (cnt_q != LAST)          cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o     = cnt_q;
    assign expired_o = run_i && (cnt_q == LAST);

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/lfs_ctrl.sv
// Flush sequencer control: flusher handshakes with data low, the data
// release in P1, flushee handshakes while the peer holds data low in P3,
// and timeout handling. All link outputs are registered.
// Assumes: clk_s_i/data_s_i are already synchronized; SETTLE covers the
// synchronizer latency after the data line is released.
module lfs_ctrl
    import lfs_pkg::*;
#(
    parameter int FLUSH_CYCLES = 36,
    parameter int SETTLE       = 4,
    parameter int CW           = 13,
    localparam int HW = $clog2(FLUSH_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          flushee_mode_i,
    input  logic          clk_s_i,
    input  logic          data_s_i,
    input  logic [CW-1:0] tmr_cnt_i,
    input  logic          tmr_exp_i,
    output logic          tmr_run_o,
    output logic          tmr_clear_o,
    output logic          ack_o,
    output logic          data_o,
    output logic          data_oe_o,
    output logic          done_o,
    output logic          timeout_o
);

    localparam logic [HW-1:0] HS_LAST = HW'(FLUSH_CYCLES - 1);

    lfs_state_e    state_q, state_d;
    logic [HW-1:0] hs_q, hs_d;
    logic          ack_q, ack_d;
    logic          dat_q, dat_d;
    logic          oe_q, oe_d;
    logic          to_q, to_d;

    // Next-state and next-output decision for the handshake sequence.
    always_comb begin
        state_d = state_q;
        hs_d    = hs_q;
        ack_d   = ack_q;
        dat_d   = dat_q;
        oe_d    = oe_q;
        to_d    = 1'b0;
        if (lfs_is_edge_wait(state_q) && tmr_exp_i) begin
            ack_d   = 1'b1;
            oe_d    = 1'b0;
            dat_d   = 1'b1;
            to_d    = 1'b1;
            state_d = ST_DONE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    ack_d = 1'b1;
                    oe_d  = 1'b0;
                    if (start_i) begin
                        if (flushee_mode_i) begin
                            state_d = ST_FE_ENTRY;
                        end else begin
                            oe_d    = 1'b1;
                            dat_d   = 1'b0;
                            hs_d    = '0;
                            state_d = ST_FL_LO;
                        end
                    end
                end
                ST_FL_LO: if (!clk_s_i) begin
                    ack_d   = 1'b0;
                    state_d = ST_FL_HI;
                end
                ST_FL_HI: if (clk_s_i) begin
                    ack_d   = 1'b1;
                    hs_d    = hs_q + 1'b1;
                    state_d = (hs_q == HS_LAST) ? ST_FL_REL : ST_FL_LO;
                end
                ST_FL_REL: if (!clk_s_i) begin
                    dat_d   = 1'b1;
                    state_d = ST_FE_ENTRY;
                end
                ST_FE_ENTRY: begin
                    oe_d    = 1'b0;
                    ack_d   = 1'b1;
                    state_d = clk_s_i ? ST_FE_SAMPLE : ST_FE_HI;
                end
                ST_FE_HI: if (clk_s_i) state_d = ST_FE_SAMPLE;
                ST_FE_SAMPLE: if (tmr_cnt_i >= CW'(SETTLE)) begin
                    ack_d   = 1'b1;
                    state_d = data_s_i ? ST_DONE : ST_FE_LO;
                end
                ST_FE_LO: if (!clk_s_i) begin
                    ack_d   = 1'b0;
                    state_d = ST_FE_HI;
                end
                ST_DONE: state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Register state, handshake count and every link-facing output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hs_q    <= '0;
            ack_q   <= 1'b1;
            dat_q   <= 1'b1;
            oe_q    <= 1'b0;
            to_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            hs_q    <= hs_d;
            ack_q   <= ack_d;
            dat_q   <= dat_d;
            oe_q    <= oe_d;
            to_q    <= to_d;
        end
    end

    assign tmr_run_o   = (state_q != ST_IDLE) && (state_q != ST_DONE) &&
                         (state_q != ST_FE_ENTRY);
    assign tmr_clear_o = (state_d != state_q);
    assign ack_o       = ack_q;
    assign data_o      = dat_q;
    assign data_oe_o   = oe_q;
    assign done_o      = (state_q == ST_DONE);
    assign timeout_o   = to_q;

    p_ack_fall_clk_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_q) |-> !$past(clk_s_i));
    p_ack_rise_clk_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q) |-> ($past(clk_s_i) || to_q));
    p_flush_data_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FL_LO || state_q == ST_FL_HI) |-> (oe_q && !dat_q));
    p_hs_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hs_q <= HW'(FLUSH_CYCLES));
    p_flushee_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FE_HI || state_q == ST_FE_SAMPLE || state_q == ST_FE_LO)
        |-> !oe_q);
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_ack_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ack_q && !oe_q));
    p_timeout_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> done_o);

endmodule

// File: rtl/link_flush_seq.sv
// Top of the three-wire link flush sequencer: synchronizes the peer clock
// and data lines, times each edge wait, and runs the flush control.
// Assumes: the data line is pulled high when nobody drives it; the link
// clock is slow relative to clk (each phase lasts several clk cycles).
module link_flush_seq #(
    parameter int FLUSH_CYCLES = 36,
    parameter int WAIT_LIMIT   = 4096,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic flushee_mode_i,
    input  logic link_clk_i,
    input  logic link_data_i,
    output logic ack_o,
    output logic data_o,
    output logic data_oe_o,
    output logic done_o,
    output logic timeout_o
);

    localparam int CW     = $clog2(WAIT_LIMIT + 1);
    localparam int SETTLE = SYNC_STAGES + 2;

    logic [1:0]    sync_out;
    logic [CW-1:0] tmr_cnt;
    logic          tmr_exp, tmr_run, tmr_clear;

    lfs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({link_data_i, link_clk_i}),
        .dout (sync_out)
    );

    lfs_timer #(.WAIT_LIMIT(WAIT_LIMIT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (tmr_run),
        .clear_i  (tmr_clear),
        .cnt_o    (tmr_cnt),
        .expired_o(tmr_exp)
    );

    lfs_ctrl #(.FLUSH_CYCLES(FLUSH_CYCLES), .SETTLE(SETTLE), .CW(CW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .flushee_mode_i(flushee_mode_i),
        .clk_s_i       (sync_out[0]),
        .data_s_i      (sync_out[1]),
        .tmr_cnt_i     (tmr_cnt),
        .tmr_exp_i     (tmr_exp),
        .tmr_run_o     (tmr_run),
        .tmr_clear_o   (tmr_clear),
        .ack_o         (ack_o),
        .data_o        (data_o),
        .data_oe_o     (data_oe_o),
        .done_o        (done_o),
        .timeout_o     (timeout_o)
    );

endmodule

// File: tb/tb_link_flush_seq.sv
module tb_link_flush_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NFLUSH     = 36;
    localparam int WLIMIT     = 64;

    // Scenario vector: [4] flushee_mode, [3] clock low at start, [2:0] extra rounds
    localparam int NVEC = 6;
    localparam logic [4:0] VEC [NVEC] = '{
        5'b0_0_000, 5'b0_0_010, 5'b0_0_101,
        5'b1_0_000, 5'b1_0_011, 5'b1_1_001
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, fe_mode = 1'b0;
    logic peer_clk = 1'b1, peer_data = 1'b1;
    logic ack, dout, doe, done, tout;
    logic line;
    int   checks = 0, errors = 0;

    assign line = (doe ? dout : 1'b1) & peer_data;

    always #(CLK_PERIOD / 2) clk = ~clk;

    link_flush_seq #(.FLUSH_CYCLES(NFLUSH), .WAIT_LIMIT(WLIMIT), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .flushee_mode_i(fe_mode),
        .link_clk_i(peer_clk), .link_data_i(line), .ack_o(ack), .data_o(dout),
        .data_oe_o(doe), .done_o(done), .timeout_o(tout)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start(input logic mode);
        @(negedge clk); fe_mode = mode; start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_ack(input logic v, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (ack == v) begin ok = 1'b1; break; end
        end
    endtask

    task automatic wait_done(output bit seen, output int cycles);
        seen = 1'b0; cycles = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            cycles++;
            if (done) begin seen = 1'b1; break; end
        end
    endtask

    task automatic run_vec(input logic [4:0] v);
        bit ok, seen, released;
        int hs, bad, falls, badoe, cyc_n;
        logic mode, pre_low;
        int rounds;
        mode = v[4]; pre_low = v[3]; rounds = int'(v[2:0]);
        hs = 0; bad = 0; falls = 0; badoe = 0; released = 0;
        if (!mode) begin
            pulse_start(1'b0);
            while (hs < 60 && !released) begin
                peer_clk = 1'b0;
                ok = 1'b0;
                for (int i = 0; i < 40; i++) begin
                    @(negedge clk);
                    if (!ack) begin ok = 1'b1; break; end
                    if (ack && line) begin released = 1'b1; break; end
                end
                if (ok) begin
                    hs++;
                    if (!(doe && !line)) bad++;
                    cyc(3); peer_clk = 1'b1;
                    wait_ack(1'b1, ok);
                end else if (!released) begin
                    break;
                end
            end
            check("R2", "handshakes without data held low", bad, 0);
            check("R3", "flusher handshake count", hs, NFLUSH);
            check("R3", "data driven high in P1 with ack high", int'(released && ack), 1);
            cyc(3); peer_data = (rounds > 0) ? 1'b0 : 1'b1; cyc(2); peer_clk = 1'b1;
        end else if (pre_low) begin
            peer_clk = 1'b0; cyc(3);
            pulse_start(1'b1);
            cyc(10);
            check("R5", "ack held high while clock low", int'(ack), 1);
            check("R5", "no done before clock rises", int'(done), 0);
            check("R6", "data released at flushee entry", int'(doe), 0);
            peer_data = (rounds > 0) ? 1'b0 : 1'b1; cyc(2); peer_clk = 1'b1;
        end else begin
            peer_data = (rounds > 0) ? 1'b0 : 1'b1; cyc(2);
            pulse_start(1'b1);
        end
        for (int r = 0; r < rounds; r++) begin
            cyc(10);
            peer_clk = 1'b0;
            wait_ack(1'b0, ok);
            if (ok) falls++;
            if (doe) badoe++;
            peer_data = (r == rounds - 1) ? 1'b1 : 1'b0;
            cyc(2); peer_clk = 1'b1;
        end
        wait_done(seen, cyc_n);
        check("R6", "extra flushee handshakes", falls, rounds);
        check("R6", "data enable during flushee rounds", badoe, 0);
        check("R7", "done seen", int'(seen), 1);
        check("R7", "timeout at normal end", int'(tout), 0);
        check("R7", "ack high at done", int'(ack), 1);
        check("R7", "data released at done", int'(doe), 0);
        @(negedge clk);
        check("R7", "done is one cycle", int'(done), 0);
        peer_clk = 1'b1; peer_data = 1'b1; cyc(5);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit seen;
        int n;
        cyc(4);
        check("R1", "ack in reset", int'(ack), 1);
        check("R1", "data enable in reset", int'(doe), 0);
        check("R1", "done in reset", int'(done), 0);
        check("R1", "timeout in reset", int'(tout), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ack after reset", int'(ack), 1);
        check("R1", "data enable after reset", int'(doe), 0);
        cyc(3);

        for (int k = 0; k < NVEC; k++) run_vec(VEC[k]);

        // R8: flusher with a peer clock that never falls
        pulse_start(1'b0);
        wait_done(seen, n);
        check("R8", "flusher timeout done", int'(seen), 1);
        check("R8", "flusher timeout flag", int'(tout), 1);
        check("R8", "latency within limit window", int'(n >= WLIMIT - 2 && n <= WLIMIT + 4), 1);
        check("R8", "ack high after timeout", int'(ack), 1);
        check("R8", "data released after timeout", int'(doe), 0);
        cyc(5);

        // R8: flushee entered with clock low, clock never rises
        peer_clk = 1'b0; cyc(3);
        pulse_start(1'b1);
        wait_done(seen, n);
        check("R8", "flushee timeout flag", int'(seen && tout), 1);
        check("R8", "ack high after flushee timeout", int'(ack), 1);
        peer_clk = 1'b1; cyc(5);

        // R1: reset in the middle of a flush returns to idle outputs
        pulse_start(1'b0);
        peer_clk = 1'b0; cyc(8);
        rst_n = 1'b0; cyc(2);
        check("R1", "ack after mid-run reset", int'(ack), 1);
        check("R1", "data enable after mid-run reset", int'(doe), 0);
        rst_n = 1'b1; peer_clk = 1'b1; cyc(5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule